// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers event flags from a set of DMA channels and turns them into per-priority-level interrupt lines. Each channel owns a 5-bit event status register and a 5-bit event enable register. Event pulses from the channel logic set status bits, and software clears them by writing ones. The OR of a channel's enabled status bits is that channel's request. A rising request sets the channel's bit in every priority level's pending register. Each level pairs its pending register with an enable register, and the level's interrupt line is high while any pending bit is also enabled.

Status is held at two levels, and each level is cleared on its own. Clearing a pending bit while the channel's enabled status is still set does not lose the request: the pending bit comes back. A read-only word reports which channels are idle. Software reaches all registers through a simple single-cycle write/read port with a combinational read path. Channel event generation lives outside this block.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, all status, channel enable, pending and level enable registers read 0 and every interrupt line is low.
- R2: A one-cycle pulse on a channel's event input sets the matching status bit at the next clock edge, whatever the enable setting. Status bit positions are: block 0, super-block 1, frame 2, half-frame 3, last-frame 4. Channel c's events are `evt_in[5c+4:5c]`, and its status register sits at byte address 0x44+8c.
- R3: Writing to a channel status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R5: Channel c's event enable register at 0x40+8c holds bits [4:0] of the write data and reads back with upper bits 0.
- R6: When a channel's enabled-status OR goes from 0 to 1, bit c of every level's pending register is set at the following clock edge. Pending registers sit at 0x00+4l for level l. A channel with status but no enable raises nothing.
- R7: Writing 1s to a level's pending register clears those bits in that level only. The bits stay clear if the channel's enabled status is clear.
- R8: If a pending bit is cleared while the channel's enabled status is still set, it reads 0 in the cycle after the write and is set again at the edge after that.
- R9: Level l's enable register at 0x10+4l holds one bit per channel. `irq_out[l]` is high exactly when the level's pending and enable registers share a set bit.
- R10: The idle word at 0x20 returns `idle_in`, bit c set meaning channel c is idle.
- R11: A pending set and a pending clear for the same bit in the same cycle leave the bit set.
- R12: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | AW | Byte address for read and write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| evt_in | input | N_CH*5 | Per-channel event pulses |
| idle_in | input | N_CH | Per-channel idle flags |
| irq_out | output | N_LVL | One interrupt line per priority level |

## Verification
Two kinds of collision can occur in the same cycle. A channel event can arrive in the cycle in which software clears the same status bit. A pending bit can be set by a rising channel request in the cycle in which software writes a clear to it. Both cases are forced by directed writes, timed to the same clock edge as the event pulse or the request edge. The bit must read back set, and the pending case is read on the very next cycle, so a later re-raise cannot hide a lost set. Constrained random traffic then mixes events, clears and enable writes against a cycle model in the bench. That model compares every read and every interrupt line.

// File: rtl/dma_irq_pkg.sv
// Shared constants for the DMA interrupt status aggregator.
// Assumes byte addressing with 32-bit word-aligned registers.
package dma_irq_pkg;
    localparam int EVW        = 5;      // event flags per channel
    localparam int EV_BLOCK   = 0;
    localparam int EV_SUPER   = 1;
    localparam int EV_FRAME   = 2;
    localparam int EV_HALF    = 3;
    localparam int EV_LAST    = 4;

    localparam int PEND_BASE  = 'h00;
    localparam int LEN_BASE   = 'h10;
    localparam int IDLE_ADR   = 'h20;
    localparam int CH_BASE    = 'h40;
    localparam int CH_STRIDE  = 8;

    function automatic int pend_adr(input int l);
        return PEND_BASE + 4 * l;
    endfunction
    function automatic int len_adr(input int l);
        return LEN_BASE + 4 * l;
    endfunction
    function automatic int chen_adr(input int c);
        return CH_BASE + CH_STRIDE * c;
    endfunction
    function automatic int chst_adr(input int c);
        return CH_BASE + CH_STRIDE * c + 4;
    endfunction
endpackage

// File: rtl/dma_irq_chstat.sv
// Per-channel event status and enable registers.
// Status bits set on event pulses and clear on write-one; a set wins over
// a clear in the same cycle. Reports the OR of enabled status bits.
module dma_irq_chstat
    import dma_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] evt,
    input  logic           en_we,
    input  logic [EVW-1:0] en_wdata,
    input  logic [EVW-1:0] st_w1c,
    output logic [EVW-1:0] st_q,
    output logic [EVW-1:0] en_q,
    output logic           any
);
    // Status flags: clear by mask, then set by events so events win
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~st_w1c) | evt;
    end

    // Event enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    // Channel request: any enabled flag set
    assign any = |(st_q & en_q);
endmodule

// File: rtl/dma_irq_level.sv
// One priority level: pending and enable registers plus interrupt line.
// Assumes any_rise is a one-cycle pulse when a channel request rises.
// A cleared bit whose channel request is still high is re-armed next cycle.
module dma_irq_level #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ch_any,
    input  logic [N_CH-1:0] any_rise,
    input  logic [N_CH-1:0] clr,
    input  logic            en_we,
    input  logic [N_CH-1:0] en_wdata,
    output logic [N_CH-1:0] pend_q,
    output logic [N_CH-1:0] en_q,
    output logic            irq
);
    logic [N_CH-1:0] rearm_q;
    logic [N_CH-1:0] set_v;

    // Bits to set this cycle: fresh request edge or re-arm after a clear
    assign set_v = any_rise | (rearm_q & ch_any);

    // Pending register: write-one clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | set_v;
    end

    // Remember clears that hit a channel whose request is still high
    always_ff @(posedge clk) begin
        if (!rst_n) rearm_q <= '0;
        else        rearm_q <= clr & ch_any;
    end

    // Level enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    // Interrupt line of this level
    assign irq = |(pend_q & en_q);
endmodule

// File: rtl/dma_irq_agg.sv
// DMA interrupt status aggregator top: register decode, per-channel status,
// per-level pending/enable and combinational read mux.
// Assumes N_CH <= DW and that all register addresses fit in AW bits.
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int N_LVL = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [N_CH*EVW-1:0] evt_in,
    input  logic [N_CH-1:0]     idle_in,
    output logic [N_LVL-1:0]    irq_out
);
    localparam int UW = (EVW > N_CH) ? EVW : N_CH;

    logic [EVW-1:0]  ch_st [N_CH];
    logic [EVW-1:0]  ch_en [N_CH];
    logic [N_CH-1:0] ch_any;
    logic [N_CH-1:0] any_q;
    logic [N_CH-1:0] any_rise;
    logic [N_CH-1:0] lv_pend [N_LVL];
    logic [N_CH-1:0] lv_en   [N_LVL];
    logic [DW-1:0]   rdata;
    logic            unused_wdata_hi;

    // Flattened views for the bound checker
    logic [N_CH*EVW-1:0]   st_flat;
    logic [N_LVL*N_CH-1:0] pend_flat;
    logic [N_LVL*N_CH-1:0] len_flat;

    assign unused_wdata_hi = ^bus_wdata[DW-1:UW];

    genvar c, l;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            logic sel_en, sel_st;
            assign sel_en = bus_wr && (bus_addr == AW'(chen_adr(c)));
            assign sel_st = bus_wr && (bus_addr == AW'(chst_adr(c)));
            dma_irq_chstat u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt_in[c*EVW +: EVW]),
                .en_we    (sel_en),
                .en_wdata (bus_wdata[EVW-1:0]),
                .st_w1c   (sel_st ? bus_wdata[EVW-1:0] : '0),
                .st_q     (ch_st[c]),
                .en_q     (ch_en[c]),
                .any      (ch_any[c])
            );
            assign st_flat[c*EVW +: EVW] = ch_st[c];
        end

        for (l = 0; l < N_LVL; l++) begin : g_lvl
            logic sel_pend, sel_len;
            assign sel_pend = bus_wr && (bus_addr == AW'(pend_adr(l)));
            assign sel_len  = bus_wr && (bus_addr == AW'(len_adr(l)));
            dma_irq_level #(.N_CH(N_CH)) u_lv (
                .clk      (clk),
                .rst_n    (rst_n),
                .ch_any   (ch_any),
                .any_rise (any_rise),
                .clr      (sel_pend ? bus_wdata[N_CH-1:0] : '0),
                .en_we    (sel_len),
                .en_wdata (bus_wdata[N_CH-1:0]),
                .pend_q   (lv_pend[l]),
                .en_q     (lv_en[l]),
                .irq      (irq_out[l])
            );
            assign pend_flat[l*N_CH +: N_CH] = lv_pend[l];
            assign len_flat[l*N_CH +: N_CH]  = lv_en[l];
        end
    endgenerate

    // Request edge detector shared by all levels
    always_ff @(posedge clk) begin
        if (!rst_n) any_q <= '0;
        else        any_q <= ch_any;
    end
    assign any_rise = ch_any & ~any_q;

    // Read mux; unmapped addresses return zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (bus_addr == AW'(pend_adr(i))) rdata[N_CH-1:0] = lv_pend[i];
            if (bus_addr == AW'(len_adr(i)))  rdata[N_CH-1:0] = lv_en[i];
        end
        if (bus_addr == AW'(IDLE_ADR)) rdata[N_CH-1:0] = idle_in;
        for (int j = 0; j < N_CH; j++) begin
            if (bus_addr == AW'(chen_adr(j))) rdata[EVW-1:0] = ch_en[j];
            if (bus_addr == AW'(chst_adr(j))) rdata[EVW-1:0] = ch_st[j];
        end
    end
    assign bus_rdata = rdata;
endmodule

// File: rtl/dma_irq_agg_chk.sv
// Checker for dma_irq_agg, attached by bind. Observes status, pending and
// enable state together with event inputs and interrupt outputs.
module dma_irq_agg_chk
    import dma_irq_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int N_LVL = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_CH*EVW-1:0]   evt_in,
    input logic [N_CH*EVW-1:0]   st_flat,
    input logic [N_CH-1:0]       ch_any,
    input logic [N_LVL*N_CH-1:0] pend_flat,
    input logic [N_LVL*N_CH-1:0] len_flat,
    input logic [N_LVL-1:0]      irq_out
);
    logic [N_CH-1:0] prev_any;
    logic [N_CH-1:0] rise;

    // Checker-local copy of the previous request vector
    always_ff @(posedge clk) begin
        if (!rst_n) prev_any <= '0;
        else        prev_any <= ch_any;
    end
    assign rise = ch_any & ~prev_any;

    // R2 / R4: every event pulse leaves its status bit set next cycle
    a_r2_evt_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((st_flat & $past(evt_in)) == $past(evt_in)));

    // R2: a status bit only rises because of an event
    a_r2_status_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_flat & ~$past(st_flat) & ~$past(evt_in)) == '0));

    genvar l;
    generate
        for (l = 0; l < N_LVL; l++) begin : g_l
            // R6 / R11: a request edge sets the pending bit, clear or not
            a_r6_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
                (rise != '0) |=> ((pend_flat[l*N_CH +: N_CH] & $past(rise)) == $past(rise)));

            // R6 / R8: a pending bit only rises for a channel that was requesting
            a_r6_pend_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
                ((pend_flat[l*N_CH +: N_CH] & ~$past(pend_flat[l*N_CH +: N_CH])
                  & ~$past(ch_any)) == '0));

            // R9: a level with nothing enabled stays quiet
            a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (len_flat[l*N_CH +: N_CH] == '0) |-> !irq_out[l]);
        end
    endgenerate
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.N_CH(N_CH), .N_LVL(N_LVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .st_flat   (st_flat),
    .ch_any    (ch_any),
    .pend_flat (pend_flat),
    .len_flat  (len_flat),
    .irq_out   (irq_out)
);

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;
    import dma_irq_pkg::*;
    localparam int N_CH = 4, N_LVL = 4, AW = 8, DW = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr = 1'b0;
    logic [AW-1:0]       bus_addr = '0;
    logic [DW-1:0]       bus_wdata = '0;
    logic [DW-1:0]       bus_rdata;
    logic [N_CH*EVW-1:0] evt_in = '0;
    logic [N_CH-1:0]     idle_in = '0;
    logic [N_LVL-1:0]    irq_out;

    always #2.5 clk = ~clk;

    dma_irq_agg #(.N_CH(N_CH), .N_LVL(N_LVL), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .idle_in(idle_in), .irq_out(irq_out));

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Cycle model built from the requirements
    logic [EVW-1:0]  m_st [N_CH];
    logic [EVW-1:0]  m_en [N_CH];
    logic [N_CH-1:0] m_pend [N_LVL];
    logic [N_CH-1:0] m_len [N_LVL];
    logic [N_CH-1:0] m_rearm [N_LVL];
    logic [N_CH-1:0] m_anyq;
    logic [DW-1:0]   got;
    logic [N_LVL-1:0] last_irq;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
        logic [DW-1:0] r = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (a == AW'(pend_adr(l))) r = DW'(m_pend[l]);
            if (a == AW'(len_adr(l)))  r = DW'(m_len[l]);
        end
        if (a == AW'(IDLE_ADR)) r = DW'(idle_in);
        for (int c = 0; c < N_CH; c++) begin
            if (a == AW'(chen_adr(c))) r = DW'(m_en[c]);
            if (a == AW'(chst_adr(c))) r = DW'(m_st[c]);
        end
        return r;
    endfunction

    function automatic logic [N_LVL-1:0] m_irq();
        logic [N_LVL-1:0] v;
        for (int l = 0; l < N_LVL; l++) v[l] = |(m_pend[l] & m_len[l]);
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < N_CH; c++) begin m_st[c] = '0; m_en[c] = '0; end
        for (int l = 0; l < N_LVL; l++) begin m_pend[l] = '0; m_len[l] = '0; m_rearm[l] = '0; end
        m_anyq = '0;
    endtask

    // One clock cycle: check irq, drive, optionally check read, advance model
    task automatic step(input logic [N_CH*EVW-1:0] ev, input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit do_rd, input string req);
        logic [N_CH-1:0] any, rise, clr;
        logic [EVW-1:0]  ns [N_CH];
        logic [EVW-1:0]  ne [N_CH];
        logic [N_CH-1:0] np [N_LVL];
        logic [N_CH-1:0] nl [N_LVL];
        logic [N_CH-1:0] nr [N_LVL];
        @(negedge clk);
        last_irq = irq_out;
        chk(irq_out == m_irq(), "R9 irq line", DW'(irq_out), DW'(m_irq()));
        evt_in = ev; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #0.5;
        got = bus_rdata;
        if (do_rd) chk(got == m_read(a), req, got, m_read(a));
        for (int c = 0; c < N_CH; c++) begin
            any[c] = |(m_st[c] & m_en[c]);
            ns[c] = (m_st[c] & ~((wr && a == AW'(chst_adr(c))) ? d[EVW-1:0] : '0)) | ev[c*EVW +: EVW];
            ne[c] = (wr && a == AW'(chen_adr(c))) ? d[EVW-1:0] : m_en[c];
        end
        rise = any & ~m_anyq;
        for (int l = 0; l < N_LVL; l++) begin
            clr = (wr && a == AW'(pend_adr(l))) ? d[N_CH-1:0] : '0;
            np[l] = (m_pend[l] & ~clr) | rise | (m_rearm[l] & any);
            nr[l] = clr & any;
            nl[l] = (wr && a == AW'(len_adr(l))) ? d[N_CH-1:0] : m_len[l];
        end
        @(posedge clk);
        for (int c = 0; c < N_CH; c++) begin m_st[c] = ns[c]; m_en[c] = ne[c]; end
        for (int l = 0; l < N_LVL; l++) begin m_pend[l] = np[l]; m_rearm[l] = nr[l]; m_len[l] = nl[l]; end
        m_anyq = any;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [N_CH*EVW-1:0] ev = '0);
        step(ev, 1'b1, a, d, 1'b0, "");
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        step('0, 1'b0, a, '0, 1'b1, req);
        chk(got == exp, req, got, exp);
    endtask

    function automatic logic [AW-1:0] pick_addr(input int k);
        if (k < N_LVL)           return AW'(pend_adr(k));
        if (k < 2*N_LVL)         return AW'(len_adr(k - N_LVL));
        if (k < 2*N_LVL + N_CH)  return AW'(chen_adr(k - 2*N_LVL));
        if (k < 2*N_LVL + 2*N_CH) return AW'(chst_adr(k - 2*N_LVL - N_CH));
        if (k == 2*N_LVL + 2*N_CH) return AW'(IDLE_ADR);
        return AW'('h34);
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_exp(AW'(pend_adr(0)), 0, "R1 pending after reset");
        rd_exp(AW'(len_adr(3)), 0, "R1 level enable after reset");
        rd_exp(AW'(chst_adr(2)), 0, "R1 status after reset");
        rd_exp(AW'(chen_adr(1)), 0, "R1 channel enable after reset");
        chk(last_irq == '0, "R1 irq after reset", DW'(last_irq), 0);

        // R5: channel enable width and readback
        wr(AW'(chen_adr(1)), 32'h1F);
        rd_exp(AW'(chen_adr(1)), 32'h1F, "R5 enable readback");
        wr(AW'(chen_adr(0)), 32'hFFFF_FFE3);
        rd_exp(AW'(chen_adr(0)), 32'h03, "R5 enable upper bits dropped");

        // R2: frame event (bit 2) on channel 0, not enabled
        wr(AW'('h34), 0, 20'h00004);
        rd_exp(AW'(chst_adr(0)), 32'h04, "R2 frame event sets status");
        rd_exp(AW'(pend_adr(0)), 0, "R6 status without enable raises nothing");

        // R6: enabling the flag raises pending one cycle after the request
        wr(AW'(chen_adr(0)), 32'h04);
        rd_exp(AW'(pend_adr(0)), 0, "R6 pending not yet set");
        rd_exp(AW'(pend_adr(3)), 32'h1, "R6 pending set in every level");

        // R9: level enable drives the line
        wr(AW'(len_adr(2)), 32'h1);
        rd_exp(AW'(len_adr(2)), 32'h1, "R9 level enable readback");
        chk(last_irq == 4'b0100, "R9 level 2 line high", DW'(last_irq), 32'h4);

        // R8: clear while request still high, re-raised afterwards
        wr(AW'(pend_adr(2)), 32'h1);
        rd_exp(AW'(pend_adr(2)), 0, "R8 cleared for one cycle");
        rd_exp(AW'(pend_adr(2)), 32'h1, "R8 re-raised");
        rd_exp(AW'(pend_adr(0)), 32'h1, "R7 other level untouched");

        // R3: write-one-clear of status
        wr(AW'(chst_adr(0)), 32'h1B);
        rd_exp(AW'(chst_adr(0)), 32'h04, "R3 zeros leave status");
        wr(AW'(chst_adr(0)), 32'h04);
        rd_exp(AW'(chst_adr(0)), 0, "R3 one clears status");
        wr(AW'(pend_adr(2)), 32'h1);
        rd_exp(AW'(pend_adr(2)), 0, "R7 pending cleared");
        rd_exp(AW'(pend_adr(2)), 0, "R7 stays clear without request");
        rd_exp(AW'(pend_adr(1)), 32'h1, "R7 level 1 keeps its bit");

        // R4: event and clear on the same bit in one cycle
        wr(AW'('h34), 0, 20'h00100);                 // ch1 half-frame (bit 3)
        wr(AW'(chst_adr(1)), 32'h0A, 20'h00040);     // ch1 super-block (bit 1) + clear bits 1,3
        rd_exp(AW'(chst_adr(1)), 32'h02, "R4 event wins over clear");

        // R11: pending set and clear in the same cycle
        wr(AW'(chen_adr(2)), 32'h01);
        wr(AW'('h34), 0, 20'h00400);                 // ch2 block event
        wr(AW'(pend_adr(1)), 32'h4);                 // request edge in this cycle
        step('0, 1'b0, AW'(pend_adr(1)), '0, 1'b1, "R11 pending readback");
        chk(got[2] == 1'b1, "R11 set wins over clear", DW'(got[2]), 1);

        // R10 and R12: idle word and unmapped reads
        idle_in = 4'hA;
        rd_exp(AW'(IDLE_ADR), 32'hA, "R10 idle word");
        idle_in = 4'h5;
        rd_exp(AW'(IDLE_ADR), 32'h5, "R10 idle word changes");
        rd_exp(AW'('h30), 0, "R12 unmapped read");
        rd_exp(AW'('h3C), 0, "R12 unmapped read");

        // Constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [N_CH*EVW-1:0] ev;
            int op, k;
            ev = ($urandom % 4 == 0) ? (N_CH*EVW)'($urandom & $urandom & $urandom) : '0;
            if ($urandom % 16 == 0) idle_in = N_CH'($urandom);
            op = $urandom % 3;
            k = $urandom % (2*N_LVL + 2*N_CH + 2);
            if (op == 0)
                step(ev, 1'b1, pick_addr(k), $urandom, 1'b0, "");
            else
                step(ev, 1'b0, pick_addr(k), '0, 1'b1, "R2 random readback vs model");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule